// File: doc/BRIEF.md
# Pipelined Four-Beat Burst SRAM

A single-port synchronous memory whose address, write data and control inputs are all captured on the rising clock edge. Each word is 36 bits wide, arranged as four 9-bit byte lanes. In each lane the top bit is a parity bit that is stored like any other bit. A read captured on one edge has its data registered and presented on the following edge.

Either of two address strobes loads a starting address. A strobe counts only while the chip enable and both chip selects are high. After the load, a two-bit beat counter walks through the other three words of the aligned group of four, one word per cycle while the active-low step input is low. A mode input picks linear order (the offset adds the beat count) or interleaved order (the offset XORs the beat count).

Writes either cover the whole word or only selected lanes. A sleep input and an output-enable input act without waiting for the clock. The data-out bus is modelled as `rdata_o` plus a drive flag. When the flag is low the bus stands for high impedance, and `rdata_o` reads zero.

The controller has three states:
- `ST_IDLE`: no burst is open.
- `ST_BURST`: a loaded address is being stepped or held.
- `ST_NAP`: sleep was seen on the last edge.

Its transitions are:
- *load*: a qualified strobe, from any state, goes to `ST_BURST`.
- *continue*: `ST_BURST` stays in `ST_BURST` while selected.
- *deselect*: `ST_BURST` goes to `ST_IDLE` when unselected.
- *doze*: sleep, from any state, goes to `ST_NAP`.
- *wake*: `ST_NAP` goes to `ST_IDLE`, or to `ST_BURST` if a load is present.

Top module: `burst_sram`

## Requirements
- R1: While `rst_n` is low, and after it is released until a read has been issued, `drive_o` is 0 and `rdata_o` is 0.
- R2: A read captured on edge k (a qualified access with `wr_all_i`=0 and `wr_lanes_i`=0) drives that word on `rdata_o`, with `drive_o`=1, after edge k+1. Without a following read, `drive_o` returns to 0 after edge k+2.
- R3: When `interleave_i`=0, beat n of a burst started at address A uses address bits [1:0] = (A[1:0]+n) mod 4, with the upper bits of A unchanged. The beat count advances on each edge where `step_n_i`=0, and wraps from 3 to 0.
- R4: When `interleave_i`=1, beat n uses address bits [1:0] = A[1:0] XOR n, with the upper bits unchanged.
- R5: Inside a burst, an edge with `step_n_i`=1 and no strobe repeats the access at the current address. Stepping then resumes from that beat.
- R6: An access with `wr_all_i`=1 writes all four lanes from `wdata_i`, whatever the value of `lane_sel_i`.
- R7: An access with `wr_all_i`=0 and `wr_lanes_i`=1 writes only lane j for each `lane_sel_i[j]`=1. Lane j is `wdata_i[9j+8:9j]`, and bit 9j+8 is its parity bit. All other lanes keep their contents.
- R8: `strobe_proc_i` and `strobe_ctrl_i` each load a new address. A strobe is ignored (no read, no write) unless `chip_en_i`, `sel_a_i` and `sel_b_i` are all 1.
- R9: If the chip is unselected during a burst, the burst closes and no access happens. A read already in flight is still delivered on the next cycle, and after that `drive_o` is 0.
- R10: While `sleep_i`=1, `drive_o` is 0 at once and all reads and writes are ignored. Stored words are kept, and any open burst is closed.
- R11: While `out_en_i`=0, `drive_o` and `rdata_o` are 0 at once. The read pipeline keeps running underneath.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset of the control registers |
| sleep_i | input | 1 | Asynchronous sleep; blocks access |
| out_en_i | input | 1 | Asynchronous output enable |
| chip_en_i | input | 1 | Chip enable |
| sel_a_i | input | 1 | Chip select A |
| sel_b_i | input | 1 | Chip select B |
| strobe_proc_i | input | 1 | Processor-side address strobe |
| strobe_ctrl_i | input | 1 | Controller-side address strobe |
| step_n_i | input | 1 | Active-low burst advance |
| interleave_i | input | 1 | 1 = interleaved order, 0 = linear order |
| wr_all_i | input | 1 | Global write of all lanes |
| wr_lanes_i | input | 1 | Byte-lane write enable |
| lane_sel_i | input | 4 | Per-lane write selects |
| addr_i | input | AW (8) | Word address |
| wdata_i | input | 36 | Write data, four 9-bit lanes |
| rdata_o | output | 36 | Read data, zero when not driven |
| drive_o | output | 1 | 1 when the data bus is driven |

## Verification
The memory is first filled with a distinct word per address. Bursts are then started at each of the four offsets in both orders, so that every wrong sequence of low address bits returns a visibly different word. A six-beat burst shows the wrap, and a held step input shows that the address repeats rather than advancing. Lane-masked writes with complementary masks separate the lanes from one another and from a global write that ignores the masks. A strobe with a select low, a write issued during sleep, a mid-burst deselect and a low output enable each show whether the block ignored, delayed or cut off the access.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
    localparam int BEAT_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_NAP   = 2'd2
    } ctrl_state_e;
endpackage

// File: rtl/burst_order.sv
module burst_order #(
    parameter int BW = 2,
    parameter bit INTERLEAVE_OK = 1'b1
) (
    input  logic [BW-1:0] start_i,
    input  logic [BW-1:0] beat_i,
    input  logic          ilv_i,
    output logic [BW-1:0] off_o
);
    generate
        if (INTERLEAVE_OK) begin : g_both
            always_comb begin
                if (ilv_i) off_o = start_i ^ beat_i;
                else       off_o = start_i + beat_i;
            end
        end else begin : g_lin
            logic unused_ilv;
            assign unused_ilv = ilv_i;
            assign off_o = start_i + beat_i;
        end
    endgenerate
endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array #(
    parameter int DEPTH  = 256,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int AW     = $clog2(DEPTH),
    localparam int WORD_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic [LANES-1:0]  we_i,
    input  logic [AW-1:0]     waddr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [AW-1:0]     raddr_i,
    output logic [WORD_W-1:0] rdata_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] q;

        always_ff @(posedge clk) begin
            if (we_i[g]) mem[waddr_i] <= wdata_i[g*LANE_W +: LANE_W];
            q <= mem[raddr_i];
        end

        assign rdata_o[g*LANE_W +: LANE_W] = q;
    end
endmodule

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
    import burst_sram_pkg::*;
#(
    parameter int AW    = 8,
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_i,
    input  logic             sel_i,
    input  logic             load_i,
    input  logic             step_n_i,
    input  logic             interleave_i,
    input  logic             wr_all_i,
    input  logic             wr_lanes_i,
    input  logic [LANES-1:0] lane_sel_i,
    input  logic [AW-1:0]    addr_i,
    output ctrl_state_e      st_o,
    output logic             acc_o,
    output logic [AW-1:0]    acc_addr_o,
    output logic [LANES-1:0] lane_we_o,
    output logic             rd_issue_o
);
    ctrl_state_e       state_q, state_d;
    logic [AW-1:0]     base_q;
    logic [BEAT_W-1:0] beat_q, beat_use, off;
    logic              take_new, cont;

    assign take_new = !sleep_i && load_i && sel_i;
    assign cont     = !sleep_i && !take_new && sel_i && (state_q == ST_BURST);
    assign beat_use = take_new ? '0
                    : ((cont && !step_n_i) ? beat_q + 1'b1 : beat_q);

    burst_order #(.BW(BEAT_W), .INTERLEAVE_OK(1'b1)) u_order (
        .start_i (base_q[BEAT_W-1:0]),
        .beat_i  (beat_use),
        .ilv_i   (interleave_i),
        .off_o   (off)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (take_new) state_d = ST_BURST;
            ST_BURST: if (!sel_i)   state_d = ST_IDLE;
            ST_NAP:   state_d = take_new ? ST_BURST : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
        if (sleep_i) state_d = ST_NAP;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // burst base and beat counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            beat_q <= '0;
        end else if (take_new) begin
            base_q <= addr_i;
            beat_q <= '0;
        end else if (cont) begin
            beat_q <= beat_use;
        end
    end

    // outputs
    always_comb begin
        acc_o      = take_new || cont;
        acc_addr_o = take_new ? addr_i : {base_q[AW-1:BEAT_W], off};
        lane_we_o  = '0;
        rd_issue_o = 1'b0;
        if (acc_o) begin
            if (wr_all_i)        lane_we_o  = '1;
            else if (wr_lanes_i) lane_we_o  = lane_sel_i;
            else                 rd_issue_o = 1'b1;
        end
    end

    assign st_o = state_q;
endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int AW     = $clog2(DEPTH),
    localparam int WORD_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_i,
    input  logic              out_en_i,
    input  logic              chip_en_i,
    input  logic              sel_a_i,
    input  logic              sel_b_i,
    input  logic              strobe_proc_i,
    input  logic              strobe_ctrl_i,
    input  logic              step_n_i,
    input  logic              interleave_i,
    input  logic              wr_all_i,
    input  logic              wr_lanes_i,
    input  logic [LANES-1:0]  lane_sel_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] rdata_o,
    output logic              drive_o
);
    logic              sel, load;
    ctrl_state_e       st;
    logic              acc, rd_issue;
    logic [AW-1:0]     acc_addr, rd_addr_q;
    logic [LANES-1:0]  lane_we;
    logic [WORD_W-1:0] dout;
    logic              rd_pend_q, valid_q;

    assign sel  = chip_en_i & sel_a_i & sel_b_i;
    assign load = strobe_proc_i | strobe_ctrl_i;

    burst_sram_ctrl #(.AW(AW), .LANES(LANES)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .sleep_i      (sleep_i),
        .sel_i        (sel),
        .load_i       (load),
        .step_n_i     (step_n_i),
        .interleave_i (interleave_i),
        .wr_all_i     (wr_all_i),
        .wr_lanes_i   (wr_lanes_i),
        .lane_sel_i   (lane_sel_i),
        .addr_i       (addr_i),
        .st_o         (st),
        .acc_o        (acc),
        .acc_addr_o   (acc_addr),
        .lane_we_o    (lane_we),
        .rd_issue_o   (rd_issue)
    );

    burst_sram_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .we_i    (lane_we),
        .waddr_i (acc_addr),
        .wdata_i (wdata_i),
        .raddr_i (rd_addr_q),
        .rdata_o (dout)
    );

    always_ff @(posedge clk) begin
        rd_addr_q <= acc_addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_pend_q <= 1'b0;
            valid_q   <= 1'b0;
        end else begin
            rd_pend_q <= rd_issue;
            valid_q   <= rd_pend_q;
        end
    end

    assign drive_o = valid_q & out_en_i & ~sleep_i;
    assign rdata_o = drive_o ? dout : '0;
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk
    import burst_sram_pkg::*;
#(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sleep_i,
    input logic          chip_en_i,
    input logic          sel_a_i,
    input logic          sel_b_i,
    input logic          strobe_proc_i,
    input logic          strobe_ctrl_i,
    input logic          step_n_i,
    input logic          wr_all_i,
    input logic          drive_o,
    input ctrl_state_e   st,
    input logic          acc,
    input logic [AW-1:0] acc_addr,
    input logic [3:0]    lane_we,
    input logic          rd_issue
);
    logic selx, strb;
    assign selx = chip_en_i && sel_a_i && sel_b_i;
    assign strb = strobe_proc_i || strobe_ctrl_i;

    a_r8_unqualified_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        !selx |-> !acc);

    a_r10_sleep_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |-> (lane_we == 4'b0 && !rd_issue));

    a_r6_global_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && wr_all_i) |-> (lane_we == 4'hF));

    a_r2_two_stage_latency: assert property (@(posedge clk) disable iff (!rst_n)
        drive_o |-> $past(rd_issue, 2));

    a_r5_pause_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BURST && selx && step_n_i && !strb && !sleep_i) |-> (acc_addr == $past(acc_addr)));

    a_r3_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BURST && selx && !strb && !sleep_i) |-> (acc_addr[AW-1:2] == $past(acc_addr[AW-1:2])));

    a_r9_deselect_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BURST && !chip_en_i) |=> (st != ST_BURST));
endmodule

bind burst_sram burst_sram_chk #(.AW(AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sleep_i       (sleep_i),
    .chip_en_i     (chip_en_i),
    .sel_a_i       (sel_a_i),
    .sel_b_i       (sel_b_i),
    .strobe_proc_i (strobe_proc_i),
    .strobe_ctrl_i (strobe_ctrl_i),
    .step_n_i      (step_n_i),
    .wr_all_i      (wr_all_i),
    .drive_o       (drive_o),
    .st            (st),
    .acc           (acc),
    .acc_addr      (acc_addr),
    .lane_we       (lane_we),
    .rd_issue      (rd_issue)
);

// File: tb/tb_burst_sram.sv
module tb_burst_sram;
    localparam int DEPTH = 256;
    localparam int AW    = 8;
    localparam int W     = 36;

    logic clk = 1'b0;
    logic rst_n, sleep_i, out_en_i, chip_en_i, sel_a_i, sel_b_i;
    logic strobe_proc_i, strobe_ctrl_i, step_n_i, interleave_i;
    logic wr_all_i, wr_lanes_i;
    logic [3:0]    lane_sel_i;
    logic [AW-1:0] addr_i;
    logic [W-1:0]  wdata_i;
    logic [W-1:0]  rdata_o;
    logic          drive_o;

    burst_sram #(.DEPTH(DEPTH)) dut (.*);

    always #5 clk = ~clk;

    // reference model state
    logic [W-1:0] mm [DEPTH];
    bit           m_busy, m_pend, e_valid;
    int           m_base, m_beat, m_paddr;
    logic [W-1:0] e_data;
    int           vectors = 0, fails = 0;
    bit           done = 0;

    function automatic logic [W-1:0] pat(int i);
        logic [W-1:0] v;
        v = W'(i) * 36'h1_0203_0405;
        return v ^ 36'h9_F00F_1234;
    endfunction

    task automatic model_step();
        bit selx, acc;
        int a, lo;
        if (!rst_n) begin
            m_busy = 0; m_pend = 0; e_valid = 0;
            return;
        end
        e_valid = m_pend;
        if (m_pend) e_data = mm[m_paddr];
        selx = chip_en_i && sel_a_i && sel_b_i;
        acc = 0; a = 0;
        if (sleep_i) m_busy = 0;
        else if ((strobe_proc_i || strobe_ctrl_i) && selx) begin
            m_busy = 1; m_base = int'(addr_i); m_beat = 0; a = m_base; acc = 1;
        end else if (m_busy && selx) begin
            if (!step_n_i) m_beat = (m_beat + 1) % 4;
            lo = interleave_i ? ((m_base % 4) ^ m_beat) : ((m_base % 4 + m_beat) % 4);
            a = (m_base / 4) * 4 + lo;
            acc = 1;
        end else if (!selx) m_busy = 0;
        m_pend = 0;
        if (acc) begin
            if (wr_all_i) mm[a] = wdata_i;
            else if (wr_lanes_i) begin
                for (int j = 0; j < 4; j++)
                    if (lane_sel_i[j]) mm[a][9*j +: 9] = wdata_i[9*j +: 9];
            end else begin
                m_pend = 1; m_paddr = a;
            end
        end
    endtask

    task automatic tick(input string tag);
        bit           xd;
        logic [W-1:0] xv;
        @(posedge clk);
        model_step();
        #2;
        xd = e_valid && out_en_i && !sleep_i;
        xv = xd ? e_data : '0;
        vectors++;
        if (drive_o !== xd || rdata_o !== xv) begin
            fails++;
            $display("FAIL %s t=%0t drive=%b data=%h expected drive=%b data=%h",
                     tag, $time, drive_o, rdata_o, xd, xv);
        end
    endtask

    task automatic quiet();
        strobe_proc_i = 0; strobe_ctrl_i = 0; step_n_i = 1;
        wr_all_i = 0; wr_lanes_i = 0; lane_sel_i = 4'h0;
    endtask

    task automatic close(input string tag);
        quiet(); chip_en_i = 0;
        tick(tag); tick(tag);
        chip_en_i = 1;
    endtask

    task automatic put(input int a, input logic [W-1:0] d, input bit all,
                       input logic [3:0] ln, input string tag);
        strobe_proc_i = 1; addr_i = AW'(a); wdata_i = d;
        wr_all_i = all; wr_lanes_i = !all; lane_sel_i = ln;
        tick(tag);
        close(tag);
    endtask

    task automatic burst_rd(input int a, input bit ilv, input int nb, input string tag);
        strobe_proc_i = 1; addr_i = AW'(a); interleave_i = ilv;
        tick(tag);
        strobe_proc_i = 0; step_n_i = 0;
        for (int k = 1; k < nb; k++) tick(tag);
        close(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 0; sleep_i = 0; out_en_i = 1; chip_en_i = 1; sel_a_i = 1; sel_b_i = 1;
        interleave_i = 0; addr_i = '0; wdata_i = '0;
        quiet();
        repeat (3) tick("R1");
        rst_n = 1;
        repeat (2) tick("R1");

        // R6: fill with global writes, lane selects left at zero
        for (int i = 0; i < DEPTH; i++) put(i, pat(i), 1'b1, 4'h0, "R6");

        burst_rd(8'h05, 0, 1, "R2");
        for (int o = 0; o < 4; o++) burst_rd(8'h40 + o, 0, 4, "R3");
        burst_rd(8'h62, 0, 6, "R3_wrap");
        for (int o = 0; o < 4; o++) burst_rd(8'h80 + o, 1, 4, "R4");

        // R7: complementary lane masks
        put(8'h10, 36'hA_AAAA_AAAA, 1'b0, 4'b0101, "R7");
        put(8'h10, 36'h5_5555_5555, 1'b0, 4'b1010, "R7");
        put(8'h11, 36'hF_FFFF_FFFF, 1'b0, 4'b1000, "R7");
        put(8'h12, 36'h0, 1'b0, 4'b0000, "R7");
        burst_rd(8'h10, 0, 4, "R7");

        // R5: pause inside a burst
        strobe_proc_i = 1; addr_i = 8'h21; interleave_i = 0;
        tick("R5");
        strobe_proc_i = 0; step_n_i = 0; tick("R5");
        step_n_i = 1; tick("R5"); tick("R5");
        step_n_i = 0; tick("R5"); tick("R5");
        close("R5");

        // R8: unqualified strobe writes nothing; controller strobe reads
        sel_b_i = 0;
        strobe_ctrl_i = 1; addr_i = 8'h30; wdata_i = '0; wr_all_i = 1;
        tick("R8");
        sel_b_i = 1; quiet(); tick("R8");
        sel_a_i = 0; strobe_proc_i = 1; addr_i = 8'h31; tick("R8");
        sel_a_i = 1; quiet(); tick("R8");
        strobe_ctrl_i = 1; addr_i = 8'h30; interleave_i = 1; tick("R8");
        strobe_ctrl_i = 0; step_n_i = 0; tick("R8"); tick("R8");
        close("R8");

        // R9: deselect after two beats; in-flight beat still delivered
        burst_rd(8'h50, 0, 2, "R9");
        strobe_proc_i = 1; addr_i = 8'h54; tick("R9");
        strobe_proc_i = 0; step_n_i = 0; chip_en_i = 0; tick("R9");
        chip_en_i = 1; tick("R9"); tick("R9");
        close("R9");

        // R10: sleep mid-burst, write attempted while asleep
        strobe_proc_i = 1; addr_i = 8'h70; interleave_i = 0; tick("R10");
        strobe_proc_i = 0; step_n_i = 0; tick("R10");
        sleep_i = 1; tick("R10");
        strobe_proc_i = 1; addr_i = 8'h70; wr_all_i = 1; wdata_i = '0; tick("R10");
        quiet(); tick("R10");
        sleep_i = 0; tick("R10");
        close("R10");
        burst_rd(8'h70, 0, 4, "R10");

        // R11: output enable dropped while reads are in flight
        strobe_proc_i = 1; addr_i = 8'h90; tick("R11");
        strobe_proc_i = 0; step_n_i = 0; tick("R11");
        out_en_i = 0; tick("R11"); tick("R11");
        out_en_i = 1; tick("R11");
        close("R11");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule